// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a synchronous request port to an external 256K x 16 asynchronous static RAM. A client issues single-word reads and writes on a valid/ready request channel. Reads return on a one-cycle response pulse. The controller drives the memory's select, strobe, address and data pins. Each phase is held for a whole number of clock cycles. Parameters give every timing minimum in nanoseconds and the clock period, and the cycle counts are derived from them by rounding up.

Writes are controlled by the write-enable pin, and output enable stays high for the whole write. The data drivers turn on only after write enable has been low for one cycle. The address and the byte-lane strobes stay frozen for as long as the memory is selected. After every read, one deselected cycle with output enable high lets the memory's outputs float before anything else uses the bus. When no transaction is active, the memory is held in standby.

Back-pressure rules: the request fields are captured on the clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the transaction is complete. A client that holds `req_valid` high simply waits, and each request is accepted exactly once. The response channel has no back-pressure, so the client must take `rsp_rdata` in the cycle `rsp_valid` is high.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset and whenever no transaction is in progress, the memory is in standby:
  - `sram_ce_n`=1, `sram_ce2`=0, `sram_we_n`=1, `sram_oe_n`=1, `sram_lb_n`=1, `sram_ub_n`=1.
  - `req_ready`=1 and `rsp_valid`=0.
- R2: A request is taken on an edge with `req_valid` and `req_ready` both high. `req_ready` is low from the following cycle until the transaction ends. A request held high across two transactions produces exactly two transactions.
- R3: A read holds the following for RD cycles, where RD = ceil(max(read cycle, address access, select access, output-enable access) / period), which is 9 at the defaults:
  - `sram_ce_n`=0, `sram_ce2`=1, `sram_we_n`=1, `sram_oe_n`=0, and both byte strobes low.
  - The bus is sampled on the edge that ends the last of these cycles.
  - `rsp_valid` is high for exactly one cycle, RD cycles after the accepting edge, with `rsp_rdata` holding all 16 bits.
- R4: Every read ends with one deselected cycle in which `sram_oe_n`=1, `sram_ce_n`=1 and `req_ready`=0. At the defaults, a write already waiting when a read ends pulls `sram_we_n` low 4 cycles after the read's last `sram_oe_n`-low cycle.
- R5: A write runs as follows, with `sram_oe_n` high throughout:
  - One select cycle with `sram_we_n` high.
  - P cycles with `sram_we_n` low, where P is 7 at the defaults: the largest of ceil(pulse width), ceil(address-valid-to-end) − 1, ceil(data setup) + 1 and ceil(write cycle) − 2.
  - One cycle with `sram_we_n` high and the memory still selected.
  - Ready returns P+2 cycles after the accepting edge.
- R6: During a write, `sram_lb_n` = not `req_be[0]` (gating bits 7..0) and `sram_ub_n` = not `req_be[1]` (gating bits 15..8), held for every selected cycle. Lanes with a zero enable keep their stored value, and a write with both enables zero changes nothing.
- R7: `sram_addr` equals the accepted address in every cycle the memory is selected. It changes only on the edge that leaves standby, while `sram_we_n` is high.
- R8: `sram_we_n` is low only while the memory is selected. It is never low in the same cycle as `sram_oe_n`.
- R9: The controller drives the accepted write data on `sram_dq` from the second write-enable-low cycle through the cycle after write enable rises. The rest of the time, and during the first write-enable-low cycle, its `sram_dq` drivers are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data |
| sram_ce_n | output | 1 | Active-low chip select |
| sram_ce2 | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Active-low write enable |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_lb_n | output | 1 | Active-low strobe for bits 7..0 |
| sram_ub_n | output | 1 | Active-low strobe for bits 15..8 |
| sram_addr | output | 18 | Memory address |
| sram_dq | inout | 16 | Bidirectional memory data |

## Verification
The properties assume that reset is applied before any request and that the external memory drives `sram_dq` only while it is selected with output enable low and write enable high. None of them depends on the values of the request fields while the controller is busy.

The stimulus changes request fields only at falling clock edges. It uses a memory model that drives the bus only under the read condition above and returns a poisoned value until the access time has elapsed since the last change of address, select or output enable. As a result, a capture that comes too early shows up as wrong read data.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_TURN, ST_WSET, ST_WLOW, ST_WDRV, ST_WEND
  } ctl_state_e;

  typedef struct packed {
    logic sel_n;
    logic sel;
    logic wr_n;
    logic rd_n;
    logic drive;
  } pin_set_t;

  function automatic int cycles_for(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic is_write(input ctl_state_e s);
    return (s == ST_WSET) || (s == ST_WLOW) || (s == ST_WDRV) || (s == ST_WEND);
  endfunction

  function automatic pin_set_t decode(input ctl_state_e s);
    pin_set_t p;
    p = '{sel_n: 1'b1, sel: 1'b0, wr_n: 1'b1, rd_n: 1'b1, drive: 1'b0};
    if (s == ST_RD || is_write(s)) begin
      p.sel_n = 1'b0;
      p.sel   = 1'b1;
    end
    if (s == ST_RD) p.rd_n = 1'b0;
    if (s == ST_WLOW || s == ST_WDRV) p.wr_n = 1'b0;
    if (s == ST_WDRV || s == ST_WEND) p.drive = 1'b1;
    return p;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
`timescale 1ns/1ps
module sram_cycle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // R3
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !done) |=> !$stable(cnt_q));
endmodule

// File: rtl/sram_seq.sv
`timescale 1ns/1ps
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int LANES     = 2,
  parameter int RD_CYC    = 9,
  parameter int PULSE_CYC = 7,
  parameter int TURN_CYC  = 1,
  parameter int CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              req_ready,
  output ctl_state_e        state_d,
  output logic [LANES-1:0]  be_d,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              capture
);
  localparam logic [CNT_W-1:0] RD_LD    = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 2);
  localparam logic [CNT_W-1:0] TURN_LD  = CNT_W'(TURN_CYC - 1);

  ctl_state_e       state_q;
  logic [LANES-1:0] be_q;
  logic             accept, load, done;
  logic [CNT_W-1:0] load_val;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign capture   = (state_q == ST_RD) && done;
  assign be_d      = accept ? req_be : be_q;

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .done(done)
  );

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        load = 1'b1;
        if (req_write) state_d = ST_WSET;
        else begin
          state_d  = ST_RD;
          load_val = RD_LD;
        end
      end
      ST_RD: if (done) begin
        state_d  = ST_TURN;
        load     = 1'b1;
        load_val = TURN_LD;
      end
      ST_TURN: if (done) state_d = ST_IDLE;
      ST_WSET: if (done) begin
        state_d = ST_WLOW;
        load    = 1'b1;
      end
      ST_WLOW: if (done) begin
        state_d  = ST_WDRV;
        load     = 1'b1;
        load_val = PULSE_LD;
      end
      ST_WDRV: if (done) begin
        state_d = ST_WEND;
        load    = 1'b1;
      end
      ST_WEND: if (done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      be_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      be_q    <= be_d;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  // R2
  hs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R4
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !req_ready);
endmodule

// File: rtl/sram_phy.sv
`timescale 1ns/1ps
module sram_phy
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_state_e        state_d,
  input  logic [LANES-1:0]  be_d,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic              capture,
  output logic              sram_ce_n,
  output logic              sram_ce2,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [LANES-1:0]  lane_n,
  output logic [ADDR_W-1:0] sram_addr,
  inout  wire  [DATA_W-1:0] sram_dq,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  pin_set_t         pins_d;
  logic             drv_q;
  logic [LANES-1:0] lane_n_d;

  assign pins_d = decode(state_d);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      if (is_write(state_d))      lane_n_d[i] = ~be_d[i];
      else if (state_d == ST_RD)  lane_n_d[i] = 1'b0;
      else                        lane_n_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_ce_n <= 1'b1;
      sram_ce2  <= 1'b0;
      sram_we_n <= 1'b1;
      sram_oe_n <= 1'b1;
      drv_q     <= 1'b0;
      lane_n    <= '1;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      sram_ce_n <= pins_d.sel_n;
      sram_ce2  <= pins_d.sel;
      sram_we_n <= pins_d.wr_n;
      sram_oe_n <= pins_d.rd_n;
      drv_q     <= pins_d.drive;
      lane_n    <= lane_n_d;
      rsp_valid <= capture;
      if (capture) rsp_rdata <= sram_dq;
    end
  end

  assign sram_addr = addr_q;
  assign sram_dq   = drv_q ? wdata_q : {DATA_W{1'bz}};

  // R8
  wr_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_oe_n && !sram_ce_n && sram_ce2));

  // R9
  drv_no_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q |-> (sram_oe_n && !sram_ce_n));

  // R7
  addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

  // R6
  lane_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(lane_n));

  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/sram_bus_ctrl.sv
`timescale 1ns/1ps
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int CLK_NS    = 8,
  parameter int T_RC_NS   = 70,
  parameter int T_AA_NS   = 70,
  parameter int T_ACE_NS  = 70,
  parameter int T_OE_NS   = 35,
  parameter int T_WC_NS   = 70,
  parameter int T_WP_NS   = 55,
  parameter int T_AW_NS   = 60,
  parameter int T_DW_NS   = 30,
  parameter int T_PWB_NS  = 60,
  parameter int TURN_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic              sram_ce_n,
  output logic              sram_ce2,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_lb_n,
  output logic              sram_ub_n,
  output logic [ADDR_W-1:0] sram_addr,
  inout  wire  [15:0]       sram_dq
);
  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;

  localparam int RD_CYC = max2(max2(cycles_for(T_RC_NS, CLK_NS), cycles_for(T_AA_NS, CLK_NS)),
                               max2(cycles_for(T_ACE_NS, CLK_NS), cycles_for(T_OE_NS, CLK_NS)));
  localparam int PULSE_CYC = max2(max2(max2(cycles_for(T_WP_NS, CLK_NS), cycles_for(T_AW_NS, CLK_NS) - 1),
                                       max2(cycles_for(T_DW_NS, CLK_NS) + 1, cycles_for(T_PWB_NS, CLK_NS) - 1)),
                                  max2(cycles_for(T_WC_NS, CLK_NS) - 2, 2));
  localparam int TURN_C = max2(TURN_CYC, 1);
  localparam int CNT_W  = $clog2(max2(max2(RD_CYC, PULSE_CYC), TURN_C) + 1);

  ctl_state_e        state_d;
  logic [LANES-1:0]  be_d;
  logic [LANES-1:0]  lane_n;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              capture;

  sram_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES), .RD_CYC(RD_CYC),
    .PULSE_CYC(PULSE_CYC), .TURN_CYC(TURN_C), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .state_d(state_d), .be_d(be_d), .addr_q(addr_q),
    .wdata_q(wdata_q), .capture(capture)
  );

  sram_phy #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_phy (
    .clk(clk), .rst_n(rst_n), .state_d(state_d), .be_d(be_d), .addr_q(addr_q),
    .wdata_q(wdata_q), .capture(capture), .sram_ce_n(sram_ce_n),
    .sram_ce2(sram_ce2), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .lane_n(lane_n), .sram_addr(sram_addr), .sram_dq(sram_dq),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign sram_lb_n = lane_n[0];
  assign sram_ub_n = lane_n[1];

  // R1
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !rsp_valid) |-> (sram_ce_n && !sram_ce2 && sram_we_n && sram_oe_n));
endmodule

// File: tb/tb_sram_bus_ctrl.sv
`timescale 1ns/1ps
module tb_sram_bus_ctrl;
  localparam int EXP_RD    = (70 + 7) / 8;
  localparam int EXP_PULSE = (55 + 7) / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic        req_ready, rsp_valid;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] rsp_rdata;
  logic        sram_ce_n, sram_ce2, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n;
  logic [17:0] sram_addr;
  wire  [15:0] sram_dq;

  sram_bus_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_ce_n(sram_ce_n), .sram_ce2(sram_ce2), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n),
    .sram_addr(sram_addr), .sram_dq(sram_dq)
  );

  // memory model
  logic [15:0] mem_m [logic [17:0]];
  logic [15:0] m_word = '0;
  logic        m_valid = 0;
  realtime     m_stamp = 0;
  logic        m_en;

  function automatic logic [15:0] lookup(input logic [17:0] a);
    return mem_m.exists(a) ? mem_m[a] : 16'h0000;
  endfunction

  always @(sram_addr or sram_ce_n or sram_ce2 or sram_oe_n) begin
    m_stamp = $realtime;
    m_valid = 1'b0;
    m_word  = lookup(sram_addr);
  end
  initial forever begin
    #1;
    m_valid = (($realtime - m_stamp) >= 70.0);
  end

  assign m_en = !sram_ce_n && sram_ce2 && !sram_oe_n && sram_we_n && !(sram_lb_n && sram_ub_n);
  assign sram_dq = m_en ? (m_valid ? m_word : 16'hA5A5) : 16'hzzzz;

  always @(posedge sram_we_n) begin
    if (rst_n && !sram_ce_n && sram_ce2) begin
      logic [15:0] w;
      w = lookup(sram_addr);
      if (!sram_lb_n) w[7:0]  = sram_dq[7:0];
      if (!sram_ub_n) w[15:8] = sram_dq[15:8];
      mem_m[sram_addr] = w;
    end
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int r_ce_low, r_we_low, r_oe_low, r_rsp_k, r_busy, r_addr_bad, r_strobe_bad;
  int r_oewe_bad, r_drv_bad, r_ce_bad, r_idle_bad;
  logic [15:0] r_rdata;
  bit r_turn_ok;

  task automatic run_txn(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    r_ce_low = 0; r_we_low = 0; r_oe_low = 0; r_rsp_k = -1; r_busy = -1;
    r_addr_bad = 0; r_strobe_bad = 0; r_oewe_bad = 0; r_drv_bad = 0;
    r_ce_bad = 0; r_idle_bad = 0; r_turn_ok = 0; r_rdata = '0;
    for (int k = 0; k < 40; k++) begin
      if (k > 0) @(negedge clk);
      if (sram_ce_n == sram_ce2) r_ce_bad++;
      if (rsp_valid) begin r_rsp_k = k; r_rdata = rsp_rdata; end
      if (req_ready) begin
        r_busy = k;
        if (!(sram_ce_n && !sram_ce2 && sram_we_n && sram_oe_n && sram_lb_n && sram_ub_n))
          r_idle_bad++;
        break;
      end
      if (!sram_ce_n) begin
        r_ce_low++;
        if (sram_addr != a) r_addr_bad++;
        if (wr ? ({sram_ub_n, sram_lb_n} != ~be) : ({sram_ub_n, sram_lb_n} != 2'b00)) r_strobe_bad++;
      end
      if (!sram_we_n) r_we_low++;
      if (!sram_oe_n) r_oe_low++;
      if (!sram_we_n && !sram_oe_n) r_oewe_bad++;
      if (wr && k >= 2 && k <= EXP_PULSE + 1 && sram_dq !== d) r_drv_bad++;
      if (!wr && k == EXP_RD) r_turn_ok = sram_oe_n && sram_ce_n;
    end
  endtask

  task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    run_txn(1'b1, a, d, be);
    chk(r_we_low == EXP_PULSE, "R5 we low cycles", r_we_low, EXP_PULSE);
    chk(r_ce_low == EXP_PULSE + 2 && r_busy == EXP_PULSE + 2, "R5 write length", r_busy, EXP_PULSE + 2);
    chk(r_oe_low == 0, "R5 oe high in write", r_oe_low, 0);
    chk(r_oewe_bad == 0 && r_ce_bad == 0, "R8 we/oe exclusive", r_oewe_bad, 0);
    chk(r_drv_bad == 0, "R9 write data on bus", r_drv_bad, 0);
    chk(r_addr_bad == 0, "R7 address frozen", r_addr_bad, 0);
    chk(r_strobe_bad == 0, "R6 lane strobes", r_strobe_bad, 0);
    chk(r_idle_bad == 0, "R1 standby after write", r_idle_bad, 0);
  endtask

  task automatic do_read(input logic [17:0] a, input logic [15:0] exp);
    run_txn(1'b0, a, 16'h0, 2'b00);
    chk(r_rdata == exp && r_rsp_k == EXP_RD, "R3 read data", {r_rsp_k[15:0], r_rdata}, {16'(EXP_RD), exp});
    chk(r_oe_low == EXP_RD && r_ce_low == EXP_RD, "R3 read window", r_oe_low, EXP_RD);
    chk(r_turn_ok && r_busy == EXP_RD + 1, "R4 turnaround cycle", r_busy, EXP_RD + 1);
    chk(r_addr_bad == 0 && r_strobe_bad == 0, "R7 read address/strobes", r_addr_bad, 0);
    chk(r_idle_bad == 0 && r_ce_bad == 0, "R1 standby after read", r_idle_bad, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R1 reset handshake", {req_ready, rsp_valid}, 2'b10);
    chk(sram_ce_n && !sram_ce2 && sram_we_n && sram_oe_n && sram_lb_n && sram_ub_n,
        "R1 reset pins", {sram_ce_n, sram_ce2, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n}, 6'b101111);
  endtask

  task automatic t_full_words;
    do_write(18'h00000, 16'h1234, 2'b11);
    do_write(18'h3FFFF, 16'hBEEF, 2'b11);
    do_write(18'h12345, 16'hC3A5, 2'b11);
    do_read(18'h00000, 16'h1234);
    do_read(18'h3FFFF, 16'hBEEF);
    do_read(18'h12345, 16'hC3A5);
    chk(r_busy > 0, "R2 ready low while busy", r_busy, 1);
  endtask

  task automatic t_byte_lanes;
    do_write(18'h00444, 16'hFFFF, 2'b11);
    do_write(18'h00444, 16'hABCD, 2'b01);
    do_read(18'h00444, 16'hFFCD);
    do_write(18'h00444, 16'h5A11, 2'b10);
    do_read(18'h00444, 16'h5ACD);
    do_write(18'h00444, 16'h0000, 2'b00);
    do_read(18'h00444, 16'h5ACD);
  endtask

  task automatic t_held_reads;
    int acc_at, rsp1, rsp2, n_rsp, n_acc;
    logic [15:0] d1;
    acc_at = -1; rsp1 = -1; rsp2 = -1; n_rsp = 0; n_acc = 0; d1 = '0;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 18'h12345;
    for (int c = 0; c < 40; c++) begin
      if (c > 0) @(negedge clk);
      if (rsp_valid) begin
        n_rsp++;
        if (rsp1 < 0) begin rsp1 = c; d1 = rsp_rdata; end else rsp2 = c;
      end
      if (req_valid && req_ready) begin
        n_acc++;
        if (acc_at < 0) acc_at = c;
        if (n_acc == 2) begin @(negedge clk); c++; req_valid = 0; end
      end
    end
    chk(n_rsp == 2, "R2 held request served twice", n_rsp, 2);
    chk(rsp1 - acc_at == EXP_RD + 1, "R3 response latency", rsp1 - acc_at, EXP_RD + 1);
    chk(rsp2 - rsp1 == EXP_RD + 2, "R4 back-to-back spacing", rsp2 - rsp1, EXP_RD + 2);
    chk(d1 == 16'hC3A5, "R3 held read data", d1, 16'hC3A5);
  endtask

  task automatic t_read_then_write;
    int last_oe, first_we;
    last_oe = -1; first_we = -1;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 18'h00444; req_be = 2'b11;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_write = 1; req_addr = 18'h00555; req_wdata = 16'h7E81;
    for (int k = 0; k < 30; k++) begin
      if (k > 0) @(negedge clk);
      if (!sram_oe_n) last_oe = k;
      if (!sram_we_n && first_we < 0) first_we = k;
      if (first_we >= 0 && req_valid && !req_ready) req_valid = 0;
      if (!sram_we_n && !sram_oe_n) chk(1'b0, "R8 overlap in turnaround", k, 0);
    end
    req_valid = 0;
    chk(first_we - last_oe == 4, "R4 read-to-write gap", first_we - last_oe, 4);
    repeat (4) @(negedge clk);
    do_read(18'h00555, 16'h7E81);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_full_words();
    t_byte_lanes();
    t_held_reads();
    t_read_then_write();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule